// File: doc/BRIEF.md
# Narrow-to-Wide Command Word Assembler

This block builds an 80-bit operand for a table engine from a narrow synchronous input port. The port carries 32 bits per beat, or only its lower 16 bits when the narrow mode is selected. Every beat comes with a 4-bit opcode. Intermediate beats carry the LOAD code. The beat that carries any other code closes the frame and launches that operation. The operand and its opcode then go to the engine as a one-cycle command pulse.

Words fill the operand from bit 0 upward, the first beat lowest. Any bits above the last word loaded read as zero. A ready output tells the source whether a closing beat would be taken in the current cycle. Ready is held low during a fixed start-up period after reset. After that it drops while the engine is busy, and while a second host port requests the table and has been given priority. LOAD beats are still collected while ready is low, so the next frame can fill while the previous command executes.

Top module: `wide_cmd_assembler`

## Requirements
- R1: For INIT_CYCLES clocks after reset is released, din_ready stays low and every beat is ignored, so no cmd_valid results; after that period din_ready follows R7.
- R2: A beat is sampled on the rising clock edge only while din_en_n is low; with din_en_n high, din and op have no effect on the latch, the word position or cmd_valid.
- R3: With cfg_half = 0, beat k of a frame (k counted from 0) is stored right aligned at bits [32k+31:32k] of the operand; bits of the third beat above bit 79 are dropped.
- R4: With cfg_half = 1, only din[15:0] is used, and beat k is stored at bits [16k+15:16k].
- R5: A beat whose op is not LOAD (LOAD = 4'h0) ends the frame. One clock later cmd_valid is high for exactly one cycle, with that op on cmd_op and the assembled operand, including that beat's word, on cmd_data. The next beat starts a new frame at position 0.
- R6: Operand bits above the last word written in a frame are zero on cmd_data, whatever earlier frames held.
- R7: After the start-up period, din_ready = !eng_busy && !(host_req && prio_host). A closing beat is accepted only while din_ready is high; a closing beat presented while it is low produces no command and leaves the partial frame intact.
- R8: After the start-up period, LOAD beats are accepted even while din_ready is low.
- R9: Beats beyond the operand capacity (3 beats in 32-bit mode, 5 in 16-bit mode) write nothing; a closing beat in that position still launches the command with the data gathered so far.
- R10: A synchronous reset (rst_n low at a rising edge) discards a partly loaded frame, so the next beat lands at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_half | input | 1 | 1 selects the 16-bit port mode |
| din_en_n | input | 1 | Beat enable, active low |
| din | input | 32 | Beat data word |
| op | input | 4 | Beat opcode; LOAD = 4'h0 |
| eng_busy | input | 1 | Table engine is still executing a command |
| host_req | input | 1 | Second host port requests the table |
| prio_host | input | 1 | 1 gives the second host port priority over this port |
| din_ready | output | 1 | A closing beat would be accepted this cycle |
| cmd_valid | output | 1 | One-cycle command launch pulse |
| cmd_op | output | 4 | Opcode of the launched command |
| cmd_data | output | 80 | Assembled operand of the launched command |

## Verification
The assertions assume that eng_busy, host_req and prio_host change only between clock edges. They also assume that cfg_half changes only when no frame is partly loaded, because the word positions of a frame are read in a single mode. The bench drives every input on the falling edge and holds cfg_half constant through each frame. It changes the mode only after a closing beat or a reset. While a closing beat is stalled, the bench holds it unchanged until din_ready rises.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned bits_for(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/cwa_init_timer.sv
module cwa_init_timer #(
   parameter int unsigned INIT_CYCLES = 800
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   localparam int unsigned CNT_W = cwa_pkg::bits_for(INIT_CYCLES);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_q != CNT_W'(INIT_CYCLES))
         cnt_q <= cnt_q + 1'b1;
   end

   assign done = (cnt_q == CNT_W'(INIT_CYCLES));
endmodule

// File: rtl/cwa_port_arbiter.sv
module cwa_port_arbiter (
   input  logic init_done,
   input  logic eng_busy,
   input  logic host_req,
   input  logic prio_host,
   output logic grant
);
   logic host_wins;

   assign host_wins = host_req & prio_host;
   assign grant     = init_done & ~eng_busy & ~host_wins;
endmodule

// File: rtl/cwa_frame_ctl.sv
module cwa_frame_ctl #(
   parameter int unsigned NCHUNK = 5,
   parameter int unsigned CW     = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          last,
   input  logic          half,
   output logic [CW-1:0] idx
);
   localparam int unsigned WIDE_SLOTS = cwa_pkg::ceil_div(NCHUNK, 2);

   logic [CW-1:0] limit;

   assign limit = half ? CW'(NCHUNK) : CW'(WIDE_SLOTS);

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx <= '0;
      else if (take) begin
         if (last)
            idx <= '0;
         else if (idx < limit)
            idx <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/cwa_word_latch.sv
module cwa_word_latch #(
   parameter int unsigned NW     = 16,
   parameter int unsigned NCHUNK = 5,
   parameter int unsigned CW     = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take,
   input  logic                 half,
   input  logic [CW-1:0]        idx,
   input  logic [2*NW-1:0]      din,
   output logic [NCHUNK*NW-1:0] merged
);
   for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
      localparam int unsigned SLOT = c / 2;
      localparam int unsigned PART = c % 2;

      logic [NW-1:0] held_q;
      logic [NW-1:0] next_v;
      logic [NW-1:0] wdata;
      logic          wr;

      always_comb begin
         if (half) begin
            wr    = (idx == CW'(c));
            wdata = din[NW-1:0];
         end else begin
            wr    = (idx == CW'(SLOT));
            wdata = din[PART*NW +: NW];
         end
         if (wr)
            next_v = wdata;
         else if (idx == '0)
            next_v = '0;
         else
            next_v = held_q;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            held_q <= '0;
         else if (take)
            held_q <= next_v;
      end

      assign merged[c*NW +: NW] = next_v;
   end
endmodule

// File: rtl/wide_cmd_assembler.sv
module wide_cmd_assembler #(
   parameter int unsigned DATA_W      = 80,
   parameter int unsigned NARROW_W    = 16,
   parameter int unsigned PORT_W      = 32,
   parameter int unsigned OP_W        = 4,
   parameter logic [3:0]  LOAD_CODE   = 4'h0,
   parameter int unsigned INIT_CYCLES = 800,
   parameter bit          HAS_NARROW  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_half,
   input  logic              din_en_n,
   input  logic [PORT_W-1:0] din,
   input  logic [OP_W-1:0]   op,
   input  logic              eng_busy,
   input  logic              host_req,
   input  logic              prio_host,
   output logic              din_ready,
   output logic              cmd_valid,
   output logic [OP_W-1:0]   cmd_op,
   output logic [DATA_W-1:0] cmd_data
);
   localparam int unsigned NCHUNK = DATA_W / NARROW_W;
   localparam int unsigned CW     = cwa_pkg::bits_for(NCHUNK);

   if (PORT_W != 2 * NARROW_W) begin : g_bad_port
      $error("PORT_W must be twice NARROW_W");
   end
   if (DATA_W % NARROW_W != 0) begin : g_bad_data
      $error("DATA_W must be a multiple of NARROW_W");
   end
   if (DATA_W <= PORT_W) begin : g_bad_depth
      $error("DATA_W must exceed PORT_W");
   end
   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("INIT_CYCLES must be at least 1");
   end

   logic              half;
   logic              init_done;
   logic              grant;
   logic              is_last;
   logic              take;
   logic [CW-1:0]     idx;
   logic [DATA_W-1:0] merged;

   if (HAS_NARROW) begin : g_mode_sel
      assign half = cfg_half;
   end else begin : g_mode_fixed
      assign half = 1'b0;
   end

   cwa_init_timer #(.INIT_CYCLES(INIT_CYCLES)) init_i (
      .clk  (clk),
      .rst_n(rst_n),
      .done (init_done)
   );

   cwa_port_arbiter arb_i (
      .init_done(init_done),
      .eng_busy (eng_busy),
      .host_req (host_req),
      .prio_host(prio_host),
      .grant    (grant)
   );

   assign is_last   = (op != OP_W'(LOAD_CODE));
   assign take      = ~din_en_n & init_done & (~is_last | grant);
   assign din_ready = grant;

   cwa_frame_ctl #(.NCHUNK(NCHUNK), .CW(CW)) frame_i (
      .clk  (clk),
      .rst_n(rst_n),
      .take (take),
      .last (is_last),
      .half (half),
      .idx  (idx)
   );

   cwa_word_latch #(.NW(NARROW_W), .NCHUNK(NCHUNK), .CW(CW)) latch_i (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .half  (half),
      .idx   (idx),
      .din   (din),
      .merged(merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_op    <= '0;
         cmd_data  <= '0;
      end else begin
         cmd_valid <= take & is_last;
         if (take & is_last) begin
            cmd_op   <= op;
            cmd_data <= merged;
         end
      end
   end
endmodule

// File: rtl/wide_cmd_assembler_chk.sv
module wide_cmd_assembler_chk #(
   parameter int unsigned OP_W        = 4,
   parameter logic [3:0]  LOAD_CODE   = 4'h0,
   parameter int unsigned INIT_CYCLES = 800
) (
   input logic            clk,
   input logic            rst_n,
   input logic            din_en_n,
   input logic [OP_W-1:0] op,
   input logic            eng_busy,
   input logic            host_req,
   input logic            prio_host,
   input logic            din_ready,
   input logic            cmd_valid,
   input logic [OP_W-1:0] cmd_op
);
   localparam int unsigned SW = cwa_pkg::bits_for(INIT_CYCLES);

   logic [SW-1:0] seen;
   logic          warm;

   always_ff @(posedge clk) begin
      if (!rst_n)
         seen <= '0;
      else if (seen != SW'(INIT_CYCLES))
         seen <= seen + 1'b1;
   end

   assign warm = (seen == SW'(INIT_CYCLES));

   // R1
   init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !warm |-> !din_ready);

   // R1
   init_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !warm |-> !cmd_valid);

   // R2
   idle_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      din_en_n |=> !cmd_valid);

   // R5
   cmd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(!din_en_n && op != OP_W'(LOAD_CODE) && din_ready));

   // R5
   cmd_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_op != OP_W'(LOAD_CODE)));

   // R7
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> !din_ready);

   // R7
   host_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && prio_host) |-> !din_ready);

   // R7
   stall_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!din_en_n && op != OP_W'(LOAD_CODE) && !din_ready) |=> !cmd_valid);

   // R7
   ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !eng_busy && !(host_req && prio_host)) |-> din_ready);
endmodule

bind wide_cmd_assembler wide_cmd_assembler_chk #(
   .OP_W(OP_W), .LOAD_CODE(LOAD_CODE), .INIT_CYCLES(INIT_CYCLES)
) chk_i (
   .clk(clk), .rst_n(rst_n), .din_en_n(din_en_n), .op(op),
   .eng_busy(eng_busy), .host_req(host_req), .prio_host(prio_host),
   .din_ready(din_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op)
);

// File: tb/wide_cmd_assembler_tb_top.sv
`timescale 1ns/1ps
module wide_cmd_assembler_tb_top;
   localparam int INIT = 800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_half = 1'b0;
   logic        din_en_n = 1'b1;
   logic [31:0] din = '0;
   logic [3:0]  op = '0;
   logic        eng_busy = 1'b0;
   logic        host_req = 1'b0;
   logic        prio_host = 1'b0;
   logic        din_ready;
   logic        cmd_valid;
   logic [3:0]  cmd_op;
   logic [79:0] cmd_data;

   int  total = 0;
   int  bad = 0;
   bit  done = 0;
   logic [31:0] wq [8];

   always #2.5 clk = ~clk;

   wide_cmd_assembler #(.INIT_CYCLES(INIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .din_en_n(din_en_n),
      .din(din), .op(op), .eng_busy(eng_busy), .host_req(host_req),
      .prio_host(prio_host), .din_ready(din_ready), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_data(cmd_data)
   );

   task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [79:0] model(input int n, input bit half);
      logic [79:0] r = '0;
      for (int i = 0; i < n; i++) begin
         if (half && i < 5) r[16*i +: 16] = wq[i][15:0];
         if (!half && i < 3)
            for (int b = 0; b < 32; b++)
               if (32*i + b < 80) r[32*i + b] = wq[i][b];
      end
      return r;
   endfunction

   task automatic beat(input logic [31:0] d, input logic [3:0] o);
      @(negedge clk);
      din_en_n = 1'b0; din = d; op = o;
   endtask

   task automatic idle();
      @(negedge clk);
      din_en_n = 1'b1; din = $urandom; op = 4'h7;
   endtask

   task automatic send_check(input int n, input logic [3:0] fop, input string req);
      for (int i = 0; i < n; i++) beat(wq[i], (i == n-1) ? fop : 4'h0);
      idle();
      check(cmd_valid == 1'b1, req, {79'b0, cmd_valid}, 80'd1);
      check(cmd_data == model(n, cfg_half), req, cmd_data, model(n, cfg_half));
      check(cmd_op == fop, req, {76'b0, cmd_op}, {76'b0, fop});
      idle();
      check(cmd_valid == 1'b0, req, {79'b0, cmd_valid}, 80'd0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; din_en_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_init();
      do_reset();
      repeat (10) @(negedge clk);
      check(din_ready == 1'b0, "R1 ready low in init", {79'b0, din_ready}, 80'd0);
      check(cmd_valid == 1'b0, "R1 no cmd after reset", {79'b0, cmd_valid}, 80'd0);
      beat(32'h1234, 4'h3);
      idle();
      check(cmd_valid == 1'b0, "R1 beat ignored in init", {79'b0, cmd_valid}, 80'd0);
      repeat (INIT) @(negedge clk);
      check(din_ready == 1'b1, "R1 ready after init", {79'b0, din_ready}, 80'd1);
   endtask

   task automatic t_wide_full();
      cfg_half = 1'b0;
      wq[0] = 32'h11112222; wq[1] = 32'h33334444; wq[2] = 32'h5555AAAA;
      send_check(3, 4'h5, "R3 R5 wide full frame");
   endtask

   task automatic t_half_full();
      cfg_half = 1'b1;
      for (int i = 0; i < 5; i++) wq[i] = 32'hBEEF0000 | (32'h1001 * (i + 1));
      send_check(5, 4'h9, "R4 half full frame");
      cfg_half = 1'b0;
   endtask

   task automatic t_zero_fill();
      cfg_half = 1'b0;
      wq[0] = '1; wq[1] = '1; wq[2] = '1;
      send_check(3, 4'h2, "R6 preload ones");
      wq[0] = 32'hCAFE0001; wq[1] = 32'h0BADF00D;
      send_check(2, 4'h4, "R6 wide zero fill");
      wq[0] = 32'h00000077;
      send_check(1, 4'hF, "R6 R5 single beat");
      cfg_half = 1'b1;
      wq[0] = 32'hFFFF1357; wq[1] = 32'hFFFF2468;
      send_check(2, 4'h6, "R6 R4 half zero fill");
      cfg_half = 1'b0;
   endtask

   task automatic t_enable_gap();
      cfg_half = 1'b0;
      wq[0] = 32'hA0A0A0A0; wq[1] = 32'hB1B1B1B1; wq[2] = 32'hC2C2C2C2;
      beat(wq[0], 4'h0);
      @(negedge clk); din_en_n = 1'b1; din = 32'hDEADDEAD; op = 4'h8;
      @(negedge clk);
      check(cmd_valid == 1'b0, "R2 disabled beat no cmd", {79'b0, cmd_valid}, 80'd0);
      beat(wq[1], 4'h0);
      @(negedge clk); din_en_n = 1'b1; din = 32'hFEEDFEED; op = 4'h0;
      beat(wq[2], 4'hA);
      idle();
      check(cmd_valid == 1'b1, "R2 gapped frame cmd", {79'b0, cmd_valid}, 80'd1);
      check(cmd_data == model(3, 1'b0), "R2 gapped frame data", cmd_data, model(3, 1'b0));
      idle();
   endtask

   task automatic t_busy();
      cfg_half = 1'b0;
      wq[0] = 32'h01020304; wq[1] = 32'h05060708; wq[2] = 32'h090A0B0C;
      @(negedge clk); eng_busy = 1'b1;
      beat(wq[0], 4'h0);
      beat(wq[1], 4'h0);
      beat(wq[2], 4'hC);
      check(din_ready == 1'b0, "R7 ready low when busy", {79'b0, din_ready}, 80'd0);
      @(negedge clk);
      check(cmd_valid == 1'b0, "R7 final stalled when busy", {79'b0, cmd_valid}, 80'd0);
      eng_busy = 1'b0;
      @(negedge clk);
      check(din_ready == 1'b1, "R7 ready when free", {79'b0, din_ready}, 80'd1);
      din_en_n = 1'b1;
      check(cmd_valid == 1'b1, "R8 R7 cmd after release", {79'b0, cmd_valid}, 80'd1);
      check(cmd_data == model(3, 1'b0), "R8 loads taken while busy", cmd_data, model(3, 1'b0));
      idle();
   endtask

   task automatic t_host();
      cfg_half = 1'b0;
      wq[0] = 32'h77778888;
      @(negedge clk); host_req = 1'b1; prio_host = 1'b1;
      beat(wq[0], 4'h1);
      check(din_ready == 1'b0, "R7 host priority ready low", {79'b0, din_ready}, 80'd0);
      @(negedge clk);
      check(cmd_valid == 1'b0, "R7 host priority blocks", {79'b0, cmd_valid}, 80'd0);
      prio_host = 1'b0;
      @(negedge clk);
      din_en_n = 1'b1;
      check(cmd_valid == 1'b1, "R7 port priority wins", {79'b0, cmd_valid}, 80'd1);
      check(cmd_data == model(1, 1'b0), "R7 port priority data", cmd_data, model(1, 1'b0));
      host_req = 1'b0;
      idle();
   endtask

   task automatic t_overflow();
      cfg_half = 1'b0;
      wq[0] = 32'h10101010; wq[1] = 32'h20202020; wq[2] = 32'h30303030;
      wq[3] = 32'h40404040; wq[4] = 32'h50505050;
      send_check(5, 4'hB, "R9 wide overflow");
      cfg_half = 1'b1;
      for (int i = 0; i < 7; i++) wq[i] = 32'h0000A000 + i;
      send_check(7, 4'hD, "R9 half overflow");
      cfg_half = 1'b0;
   endtask

   task automatic t_reset_mid();
      cfg_half = 1'b0;
      beat(32'h99999999, 4'h0);
      beat(32'h88888888, 4'h0);
      idle();
      do_reset();
      @(negedge clk);
      check(din_ready == 1'b0, "R10 R1 ready low after reset", {79'b0, din_ready}, 80'd0);
      repeat (INIT + 2) @(negedge clk);
      wq[0] = 32'h00C0FFEE;
      send_check(1, 4'h3, "R10 frame restarts at slot 0");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_init();
      t_wide_full();
      t_half_full();
      t_zero_fill();
      t_enable_gap();
      t_busy();
      t_host();
      t_overflow();
      t_reset_mid();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule